// File: doc/BRIEF.md
# Multi-clock token step controller

This block is the control shell that turns a fixed target design into a latency-insensitive model. The whole model runs on a single host clock. Tokens enter through decoupled input channels and leave through decoupled output channels. Every channel is bound to one of several target clock domains. A separate decoupled clock-token channel carries one enable bit per domain and says which domains tick in the next target step.

The controller keeps a "done" flag for every channel. It finishes a target step once every output has been sent, every input is presenting a token, and a clock token is available. In the finishing cycle it produces a one-cycle gate pulse for each domain that is enabled, and the target state of that domain updates only on that pulse. At each step boundary the done flags are seeded from the inverted enable bit of the channel's domain. Channels in idle domains therefore count as already complete and move no token.

The channel payload bits travel on the target datapath and do not pass through this controller. The default configuration has two input channels, two output channels and two domains:

- Output 0 depends combinationally on input 0.
- Output 1 has no input dependency.
- Input i and output i both belong to domain i.

Top module: `tok_step_ctrl`

## Requirements
- R1: After reset every done flag is clear and every domain enable is 1. With no input valid, output 1 presents valid, output 0 does not, and step, clock-token ready, input ready and all gates are low.
- R2: Output o asserts valid exactly when its done flag is clear and every input it depends on presents valid. Output 0 depends on input 0; output 1 has no dependency.
- R3: step_o is high exactly when every output is done-or-firing (firing = valid and ready), every input presents valid, and the clock-token channel presents valid.
- R4: ctok_ready_o equals the step condition without the clock-token valid term.
- R5: Input i asserts ready exactly when step_o is high and its done flag is clear.
- R6: On a step, each channel's done flag loads the inverse of its domain's bit in ctok_en_i (bit d = domain d). Otherwise it loads done-or-firing. A channel in an idle domain therefore moves no token in the next step.
- R7: Each domain enable register resets to 1, loads its bit of ctok_en_i on a step, and holds otherwise.
- R8: dom_gate_o[d] is high exactly when step_o is high and domain d's enable register is 1.
- R9: No token is lost or duplicated. For each input, the tokens consumed equal the gate pulses of its domain. For each output, the tokens emitted minus the gate pulses of its domain is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous host reset |
| in_valid_i | input | N_IN | Input channel token present |
| in_ready_o | output | N_IN | Input channel token consumed |
| out_valid_o | output | N_OUT | Output channel token present |
| out_ready_i | input | N_OUT | Output channel token accepted |
| ctok_valid_i | input | 1 | Clock token present |
| ctok_en_i | input | N_DOM | Clock token payload, bit d enables domain d |
| ctok_ready_o | output | 1 | Clock token consumed when high with valid |
| step_o | output | 1 | Target step finishes this host cycle |
| dom_gate_o | output | N_DOM | Per-domain gated clock enable pulse |

## Verification
The handshake outputs, step_o and the gates are combinational in the current inputs and the registered flags. The bench drives its inputs after the falling edge, waits one time unit, and then compares every output against its own channel model in that same cycle. Done flags and domain enables change on the next rising edge. The model advances at that edge, so an effect of R6 or R7 is checked in the cycle after the step that caused it. The token counts for R9 are compared after the random run ends.

// File: rtl/tok_pkg.sv
package tok_pkg;
  // true when every input selected by mask presents valid
  function automatic logic deps_met(input logic [31:0] valid, input logic [31:0] mask);
    return &(valid | ~mask);
  endfunction
endpackage

// File: rtl/tok_out_chan.sv
module tok_out_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dom_bit_i,
  input  logic deps_ok_i,
  input  logic ready_i,
  output logic valid_o,
  output logic done_o
);
  logic done_q;
  logic done_d;

  assign valid_o = ~done_q & deps_ok_i;
  assign done_o  = done_q | (valid_o & ready_i);
  assign done_d  = step_i ? ~dom_bit_i : done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  AST_NO_REEMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !step_i) |=> !valid_o); // R6
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !dom_bit_i) |=> !valid_o); // R6
endmodule

// File: rtl/tok_in_chan.sv
module tok_in_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dom_bit_i,
  input  logic valid_i,
  output logic ready_o
);
  logic done_q;
  logic done_d;

  assign ready_o = step_i & ~done_q;
  assign done_d  = step_i ? ~dom_bit_i : (done_q | (ready_o & valid_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= done_d;
  end

  AST_IDLE_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !dom_bit_i) |=> !ready_o); // R6
endmodule

// File: rtl/tok_dom_en.sv
module tok_dom_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic tok_bit_i,
  output logic gate_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= 1'b1;
    else if (step_i) en_q <= tok_bit_i;
  end

  assign gate_o = en_q & step_i;

  AST_GATE_IN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> step_i); // R8
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(en_q)); // R7
endmodule

// File: rtl/tok_step_ctrl.sv
module tok_step_ctrl #(
  parameter int unsigned N_IN  = 2,
  parameter int unsigned N_OUT = 2,
  parameter int unsigned N_DOM = 2,
  parameter int unsigned IN_DOM  [N_IN]  = '{0, 1},
  parameter int unsigned OUT_DOM [N_OUT] = '{0, 1},
  parameter logic [N_OUT-1:0][N_IN-1:0] OUT_DEP = '{2'b00, 2'b01}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_valid_i,
  output logic [N_IN-1:0]  in_ready_o,
  output logic [N_OUT-1:0] out_valid_o,
  input  logic [N_OUT-1:0] out_ready_i,
  input  logic             ctok_valid_i,
  input  logic [N_DOM-1:0] ctok_en_i,
  output logic             ctok_ready_o,
  output logic             step_o,
  output logic [N_DOM-1:0] dom_gate_o
);
  localparam int unsigned PAD_IN = 32 - N_IN;

  logic [N_OUT-1:0] out_done;
  logic             all_done;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int unsigned D = OUT_DOM[o];
    logic deps_ok;
    assign deps_ok = tok_pkg::deps_met({{PAD_IN{1'b0}}, in_valid_i},
                                       {{PAD_IN{1'b0}}, OUT_DEP[o]});
    tok_out_chan i_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (step_o),
      .dom_bit_i (ctok_en_i[D]),
      .deps_ok_i (deps_ok),
      .ready_i   (out_ready_i[o]),
      .valid_o   (out_valid_o[o]),
      .done_o    (out_done[o])
    );
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    localparam int unsigned D = IN_DOM[i];
    tok_in_chan i_in (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (step_o),
      .dom_bit_i (ctok_en_i[D]),
      .valid_i   (in_valid_i[i]),
      .ready_o   (in_ready_o[i])
    );
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    tok_dom_en i_dom (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (step_o),
      .tok_bit_i (ctok_en_i[d]),
      .gate_o    (dom_gate_o[d])
    );
  end

  assign all_done     = (&out_done) & (&in_valid_i);
  assign ctok_ready_o = all_done;
  assign step_o       = all_done & ctok_valid_i;

  AST_STEP_TAKES_TOKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (ctok_valid_i && ctok_ready_o)); // R4
  AST_STEP_NEEDS_INPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (&in_valid_i)); // R3
  AST_TAKE_ONLY_ON_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|in_ready_o) |-> step_o); // R5
endmodule

// File: tb/test_tok_step_ctrl.sv
module test_tok_step_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] in_valid = '0, in_ready, out_valid, out_ready = '0, ctok_en = '0, gate;
  logic       ctok_valid = 1'b0, ctok_ready, step;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] m_fi = '0, m_fo = '0, m_en = 2'b11;
  int cons_in [2], emit_out [2], gates [2];

  always #10 clk = ~clk;

  tok_step_ctrl i_tok_step_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .ctok_valid_i(ctok_valid), .ctok_en_i(ctok_en), .ctok_ready_o(ctok_ready),
    .step_o(step), .dom_gate_o(gate)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_valid(input logic [1:0] fo, input logic [1:0] iv);
    return {~fo[1], ~fo[0] & iv[0]}; // out0 depends on in0
  endfunction

  task automatic cycle(input logic [1:0] iv, input logic [1:0] orr,
                       input logic tv, input logic [1:0] te);
    logic [1:0] ev, fof, eir, eg;
    logic all, es;
    @(negedge clk);
    in_valid = iv; out_ready = orr; ctok_valid = tv; ctok_en = te;
    #1;
    ev  = exp_valid(m_fo, iv);
    fof = m_fo | (ev & orr);
    all = (&fof) & (&iv);
    es  = all & tv;
    eir = {2{es}} & ~m_fi;
    eg  = {2{es}} & m_en;
    chk("R2 out_valid", {6'b0, out_valid}, {6'b0, ev});
    chk("R3 step", {7'b0, step}, {7'b0, es});
    chk("R4 ctok_ready", {7'b0, ctok_ready}, {7'b0, all});
    chk("R5 in_ready", {6'b0, in_ready}, {6'b0, eir});
    chk("R8 gate", {6'b0, gate}, {6'b0, eg});
    for (int k = 0; k < 2; k++) begin
      if (in_ready[k] && iv[k]) cons_in[k]++;
      if (out_valid[k] && orr[k]) emit_out[k]++;
      if (gate[k]) gates[k]++;
    end
    if (es) begin
      m_fi = ~te; m_fo = ~te; m_en = te;
    end else begin
      m_fo = fof;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 2; k++) begin cons_in[k] = 0; emit_out[k] = 0; gates[k] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset out_valid", {6'b0, out_valid}, 8'h02);
    chk("R1 reset step", {5'b0, step, ctok_ready, |gate}, 8'h00);
    chk("R1 reset in_ready", {6'b0, in_ready}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    // R1: first step must emit both outputs before finishing
    cycle(2'b11, 2'b00, 1'b1, 2'b01);
    cycle(2'b11, 2'b01, 1'b1, 2'b01);
    cycle(2'b11, 2'b10, 1'b1, 2'b01);   // step here, enables next = 01
    // R6/R7: domain 1 idle, output 1 silent, step with only out0
    cycle(2'b11, 2'b00, 1'b0, 2'b00);
    #1 chk("R6 idle out1 silent", {7'b0, out_valid[1]}, 8'h00);
    cycle(2'b11, 2'b01, 1'b1, 2'b10);   // step: gate only dom0
    cycle(2'b11, 2'b10, 1'b1, 2'b11);   // step: gate only dom1
    // R7 all domains off, then back on
    cycle(2'b11, 2'b11, 1'b1, 2'b00);
    cycle(2'b11, 2'b00, 1'b1, 2'b11);
    #1 chk("R7 gate none enabled", {6'b0, gate}, 8'h00);
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] iv, orr, te;
      iv  = {($urandom % 4) != 0, ($urandom % 4) != 0};
      orr = {($urandom % 3) != 0, ($urandom % 3) != 0};
      te  = 2'($urandom);
      cycle(iv, orr, ($urandom % 4) != 0, te);
    end
    for (int k = 0; k < 2; k++) begin
      chk("R9 inputs consumed vs gates", 8'(cons_in[k]), 8'(gates[k]));
      chk("R9 outputs emitted vs gates", {7'b0, (emit_out[k] - gates[k]) inside {0, 1}}, 8'h01);
    end
    chk("R9 steps happened", {7'b0, gates[0] > 100}, 8'h01);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule